// File: doc/BRIEF.md
# Port Polling Request Scheduler

This block decides which of up to 32 memory ports may issue its next burst for one transfer direction. A pointer visits the active ports one per cycle in a fixed circular order. A port is granted only if three things hold: software has enabled it, its data buffer reports ready, and it has no burst outstanding. When a port is granted, the block takes that port's current address and burst length from a small per-port configuration store. It advances the stored address by one burst and pushes a request of index, burst length and address into a queue. A downstream dispatcher drains that queue.

Each port has an in-flight flag. A grant clears the flag, and a completion that carries the port index sets it again, so each port has at most one burst outstanding. When a port's advanced address reaches or passes its end address, the block withdraws the port's enable, and no completion can bring it back. A start pulse loads the number of active ports and the enable mask, re-arms every flag and returns the pointer to port 0. The configuration store is written before start, or while the ports being written are idle. The design uses one instance for reads and a second, identical instance for writes.

Top module: `port_poll_sched`

## Requirements
- R1: After reset the request queue is empty (`req_vld_o` low), and no port is granted until `start_i` has been pulsed.
- R2: After start the pointer visits ports 0 to `num_ports_i`-1 in increasing order and wraps, so ready ports appear in the queue in index order. A port with index at or above the active count is never granted, even when its enable bit is set.
- R3: A port is granted only when its enable bit is 1, its `port_rdy_i` bit is 1 and its in-flight flag is set. A port that is not ready or not enabled is skipped and later granted once it qualifies.
- R4: Each queue entry carries the port index, the port's burst length and the port's current address. Every grant advances that port's current address by its burst length.
- R5: A granted port is not granted again until `done_i` is pulsed with `done_idx_i` equal to its index. That pulse makes the port eligible again.
- R6: A grant of one port and a completion of a different port in the same cycle both take effect.
- R7: When a grant and a completion name the same port in one cycle, the port stays in flight, so it yields exactly one queue entry.
- R8: When a grant advances a port's address to a value greater than or equal to its end address, the port is disabled and produces no further entries, even after a completion.
- R9: Polling holds while the queue together with the request in the lookup stage would exceed `Q_DEPTH`. No request is lost or overwritten, and polling resumes once the dispatcher pops.
- R10: `start_i` re-arms every in-flight flag, loads the enable mask and active count, and restarts polling at port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load count and mask, re-arm flags, pointer to 0 |
| num_ports_i | input | $clog2(NPORTS+1) | Number of active ports |
| en_mask_i | input | NPORTS | Initial per-port enable |
| port_rdy_i | input | NPORTS | Per-port buffer ready |
| cfg_we_i | input | 1 | Configuration store write strobe |
| cfg_idx_i | input | $clog2(NPORTS) | Port written |
| cfg_cur_i | input | ADDR_W | Current (start) address |
| cfg_end_i | input | ADDR_W | End address |
| cfg_bc_i | input | BC_W | Burst length in words |
| done_i | input | 1 | Completion strobe |
| done_idx_i | input | $clog2(NPORTS) | Index of completed port |
| req_vld_o | output | 1 | Queue head valid |
| req_idx_o | output | $clog2(NPORTS) | Head port index |
| req_bc_o | output | BC_W | Head burst length |
| req_addr_o | output | ADDR_W | Head address |
| req_pop_i | input | 1 | Dispatcher pops the head |

## Verification
The hardest case to reach is a grant and a completion in the same cycle. The grant depends on where the internal pointer stands, and the pointer cannot be seen at the ports. The bench gets there by counting cycles from the start pulse, since the pointer starts at port 0 and moves one port per cycle while the queue has room. In that cycle it raises a port's ready bit and drives the completion strobe, naming either that port or its neighbour. The queue-full hold is reached by leaving the queue undrained. The bench then sends a completion during the hold and checks that the drained entries come out in order with the correct advanced addresses.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned PPS_PORTS_MAX = 32;
  localparam int unsigned PPS_ADDR_W    = 32;
  localparam int unsigned PPS_BC_W      = 7;
  localparam int unsigned PPS_Q_DEPTH   = 4;
endpackage

// File: rtl/pps_flags.sv
module pps_flags #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic              set_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  output logic [NPORTS-1:0] flags_o
);
  for (genvar g = 0; g < NPORTS; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     flags_o[g] <= 1'b1;
      else if (init_i)                                 flags_o[g] <= 1'b1;
      else if (clr_i && clr_idx_i == IDX_W'(g))        flags_o[g] <= 1'b0; // clear wins
      else if (set_i && set_idx_i == IDX_W'(g))        flags_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/pps_cfg_store.sv
module pps_cfg_store #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BC_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_cur_i,
  input  logic [ADDR_W-1:0] wr_end_i,
  input  logic [BC_W-1:0]   wr_bc_i,
  input  logic              adv_i,
  input  logic [IDX_W-1:0]  adv_idx_i,
  input  logic [ADDR_W-1:0] adv_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_cur_o,
  output logic [ADDR_W-1:0] rd_end_o,
  output logic [BC_W-1:0]   rd_bc_o
);
  logic [ADDR_W-1:0] cur_q [NPORTS];
  logic [ADDR_W-1:0] end_q [NPORTS];
  logic [BC_W-1:0]   bc_q  [NPORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NPORTS; k++) begin
        cur_q[k] <= '0;
        end_q[k] <= '0;
        bc_q[k]  <= '0;
      end
    end else begin
      for (int k = 0; k < NPORTS; k++) begin
        if (wr_i && wr_idx_i == IDX_W'(k)) begin
          cur_q[k] <= wr_cur_i;
          end_q[k] <= wr_end_i;
          bc_q[k]  <= wr_bc_i;
        end else if (adv_i && adv_idx_i == IDX_W'(k)) begin
          cur_q[k] <= adv_addr_i;
        end
      end
    end
  end

  assign rd_cur_o = cur_q[rd_idx_i];
  assign rd_end_o = end_q[rd_idx_i];
  assign rd_bc_o  = bc_q[rd_idx_i];
endmodule

// File: rtl/pps_fifo.sv
module pps_fifo #(
  parameter int unsigned WIDTH = 44,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             vld_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic             push_ok, pop_ok;

  assign vld_o   = cnt_o != '0;
  assign full_o  = cnt_o == CNT_W'(DEPTH);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && vld_o;
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wp_q] <= din_i;
        wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (pop_ok) rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      if (push_ok && !pop_ok)      cnt_o <= cnt_o + 1'b1;
      else if (pop_ok && !push_ok) cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/port_poll_sched.sv
module port_poll_sched import pps_pkg::*; #(
  parameter int unsigned NPORTS  = PPS_PORTS_MAX,
  parameter int unsigned ADDR_W  = PPS_ADDR_W,
  parameter int unsigned BC_W    = PPS_BC_W,
  parameter int unsigned Q_DEPTH = PPS_Q_DEPTH,
  localparam int unsigned IDX_W  = $clog2(NPORTS),
  localparam int unsigned NUM_W  = $clog2(NPORTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_W-1:0]  num_ports_i,
  input  logic [NPORTS-1:0] en_mask_i,
  input  logic [NPORTS-1:0] port_rdy_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_cur_i,
  input  logic [ADDR_W-1:0] cfg_end_i,
  input  logic [BC_W-1:0]   cfg_bc_i,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  done_idx_i,
  output logic              req_vld_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic [BC_W-1:0]   req_bc_o,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              req_pop_i
);
  localparam int unsigned CNT_W = $clog2(Q_DEPTH + 1);
  localparam int unsigned REQ_W = IDX_W + BC_W + ADDR_W;
  localparam logic [CNT_W:0] DEPTH_C = (CNT_W + 1)'(Q_DEPTH);

  logic [NUM_W-1:0]  num_q;
  logic [NPORTS-1:0] en_q;
  logic [NPORTS-1:0] flags;
  logic [IDX_W-1:0]  ptr_q;
  logic [NUM_W-1:0]  ptr_nxt;
  logic              s1_vld_q;
  logic [IDX_W-1:0]  s1_idx_q;
  logic              stall, in_range, grant, retire;
  logic [CNT_W-1:0]  q_cnt;
  logic [CNT_W:0]    occ;
  logic              q_full;
  logic [ADDR_W-1:0] rd_cur, rd_end, new_cur;
  logic [BC_W-1:0]   rd_bc;
  logic [REQ_W-1:0]  q_dout;

  // Stage 0: poll one port per cycle
  assign occ      = {1'b0, q_cnt} + {{CNT_W{1'b0}}, s1_vld_q};
  assign stall    = occ >= DEPTH_C;
  assign in_range = NUM_W'(ptr_q) < num_q;
  assign grant    = !stall && !start_i && in_range &&
                    flags[ptr_q] && en_q[ptr_q] && port_rdy_i[ptr_q];
  assign ptr_nxt  = NUM_W'(ptr_q) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q    <= '0;
      ptr_q    <= '0;
      s1_vld_q <= 1'b0;
      s1_idx_q <= '0;
    end else begin
      s1_vld_q <= grant;
      s1_idx_q <= ptr_q;
      if (start_i) begin
        num_q <= num_ports_i;
        ptr_q <= '0;
      end else if (!stall) begin
        ptr_q <= (ptr_nxt >= num_q) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  pps_flags #(.NPORTS(NPORTS), .IDX_W(IDX_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (start_i),
    .clr_i     (grant),
    .clr_idx_i (ptr_q),
    .set_i     (done_i),
    .set_idx_i (done_idx_i),
    .flags_o   (flags)
  );

  // Stage 1: lookup, advance, push, retire
  pps_cfg_store #(.NPORTS(NPORTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BC_W(BC_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_cur_i   (cfg_cur_i),
    .wr_end_i   (cfg_end_i),
    .wr_bc_i    (cfg_bc_i),
    .adv_i      (s1_vld_q),
    .adv_idx_i  (s1_idx_q),
    .adv_addr_i (new_cur),
    .rd_idx_i   (s1_idx_q),
    .rd_cur_o   (rd_cur),
    .rd_end_o   (rd_end),
    .rd_bc_o    (rd_bc)
  );

  assign new_cur = rd_cur + ADDR_W'(rd_bc);
  assign retire  = s1_vld_q && (new_cur >= rd_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (start_i) en_q <= en_mask_i;
    else if (retire)  en_q[s1_idx_q] <= 1'b0;
  end

  pps_fifo #(.WIDTH(REQ_W), .DEPTH(Q_DEPTH)) u_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (s1_vld_q),
    .din_i  ({s1_idx_q, rd_bc, rd_cur}),
    .pop_i  (req_pop_i),
    .dout_o (q_dout),
    .vld_o  (req_vld_o),
    .full_o (q_full),
    .cnt_o  (q_cnt)
  );

  assign {req_idx_o, req_bc_o, req_addr_o} = q_dout;
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned NUM_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stall_i,
  input logic              grant_i,
  input logic [IDX_W-1:0]  ptr_i,
  input logic [NUM_W-1:0]  num_i,
  input logic              s1_vld_i,
  input logic [IDX_W-1:0]  s1_idx_i,
  input logic [NPORTS-1:0] flags_i,
  input logic              q_full_i,
  input logic              done_i,
  input logic [IDX_W-1:0]  done_idx_i
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full_i |-> !s1_vld_i); // R9
  AST_STALL_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !s1_vld_i); // R9
  AST_INFLIGHT_MARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_i |-> !flags_i[s1_idx_i]); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && done_i && done_idx_i == ptr_i) |=> !flags_i[$past(ptr_i)]); // R7
  AST_DONE_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i && !(grant_i && done_idx_i == ptr_i)) |=> flags_i[$past(done_idx_i)]); // R5
  AST_PTR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_i != '0) |-> (NUM_W'(ptr_i) < num_i)); // R2
endmodule

bind port_poll_sched pps_chk #(.NPORTS(NPORTS), .IDX_W(IDX_W), .NUM_W(NUM_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stall_i    (stall),
  .grant_i    (grant),
  .ptr_i      (ptr_q),
  .num_i      (num_q),
  .s1_vld_i   (s1_vld_q),
  .s1_idx_i   (s1_idx_q),
  .flags_i    (flags),
  .q_full_i   (q_full),
  .done_i     (done_i),
  .done_idx_i (done_idx_i)
);

// File: tb/port_poll_sched_tb_top.sv
module port_poll_sched_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  num_ports_i = '0;
  logic [31:0] en_mask_i = '0;
  logic [31:0] port_rdy_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [4:0]  cfg_idx_i = '0;
  logic [31:0] cfg_cur_i = '0;
  logic [31:0] cfg_end_i = '0;
  logic [6:0]  cfg_bc_i = '0;
  logic        done_i = 1'b0;
  logic [4:0]  done_idx_i = '0;
  logic        req_vld_o;
  logic [4:0]  req_idx_o;
  logic [6:0]  req_bc_o;
  logic [31:0] req_addr_o;
  logic        req_pop_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  port_poll_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .num_ports_i(num_ports_i),
    .en_mask_i(en_mask_i), .port_rdy_i(port_rdy_i), .cfg_we_i(cfg_we_i),
    .cfg_idx_i(cfg_idx_i), .cfg_cur_i(cfg_cur_i), .cfg_end_i(cfg_end_i),
    .cfg_bc_i(cfg_bc_i), .done_i(done_i), .done_idx_i(done_idx_i),
    .req_vld_o(req_vld_o), .req_idx_o(req_idx_o), .req_bc_o(req_bc_o),
    .req_addr_o(req_addr_o), .req_pop_i(req_pop_i)
  );

  typedef struct packed {
    logic        dn;
    logic [4:0]  di;
    logic        ev;
    logic [4:0]  ei;
    logic [6:0]  eb;
    logic [31:0] ea;
  } row_t;

  // done pulse (optional), then expected queue head or none
  localparam row_t TBL [12] = '{
    '{1'b0, 5'd0, 1'b1, 5'd0, 7'd16, 32'd0},    // R2 R4 first pass in index order
    '{1'b0, 5'd0, 1'b1, 5'd1, 7'd8,  32'd100},
    '{1'b0, 5'd0, 1'b1, 5'd2, 7'd4,  32'd200},
    '{1'b0, 5'd0, 1'b1, 5'd3, 7'd32, 32'd300},
    '{1'b1, 5'd0, 1'b1, 5'd0, 7'd16, 32'd16},   // R5 re-armed, R4 advanced
    '{1'b1, 5'd1, 1'b0, 5'd0, 7'd0,  32'd0},    // R8 port 1 retired
    '{1'b1, 5'd0, 1'b1, 5'd0, 7'd16, 32'd32},
    '{1'b1, 5'd0, 1'b1, 5'd0, 7'd16, 32'd48},
    '{1'b1, 5'd0, 1'b0, 5'd0, 7'd0,  32'd0},    // R8 port 0 reached end
    '{1'b1, 5'd2, 1'b1, 5'd2, 7'd4,  32'd204},
    '{1'b1, 5'd3, 1'b1, 5'd3, 7'd32, 32'd332},
    '{1'b1, 5'd5, 1'b0, 5'd0, 7'd0,  32'd0}     // R2 index beyond count
  };

  task automatic cfg_write(input logic [4:0] idx, input logic [31:0] cur,
                           input logic [31:0] last, input logic [6:0] bc);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_cur_i = cur; cfg_end_i = last; cfg_bc_i = bc;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_start(input logic [5:0] num, input logic [31:0] mask);
    start_i = 1'b1; num_ports_i = num; en_mask_i = mask;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic pulse_done(input logic [4:0] idx);
    done_i = 1'b1; done_idx_i = idx;
    @(negedge clk_i);
    done_i = 1'b0;
  endtask

  task automatic pop_expect(input logic [4:0] idx, input logic [6:0] bc,
                            input logic [31:0] addr, input string tag);
    for (int w = 0; w < 20 && !req_vld_o; w++) @(negedge clk_i);
    n_chk++;
    if (!req_vld_o || req_idx_o != idx || req_bc_o != bc || req_addr_o != addr) begin
      n_err++;
      $display("FAIL %s: got vld=%0b idx=%0d bc=%0d addr=%0d, expected idx=%0d bc=%0d addr=%0d",
               tag, req_vld_o, req_idx_o, req_bc_o, req_addr_o, idx, bc, addr);
    end
    if (req_vld_o) begin
      req_pop_i = 1'b1;
      @(negedge clk_i);
      req_pop_i = 1'b0;
    end
  endtask

  task automatic expect_none(input int cycles, input string tag);
    logic seen = 1'b0;
    for (int w = 0; w < cycles; w++) begin
      if (req_vld_o) seen = 1'b1;
      @(negedge clk_i);
    end
    n_chk++;
    if (seen) begin
      n_err++;
      $display("FAIL %s: got unexpected entry idx=%0d addr=%0d, expected none",
               tag, req_idx_o, req_addr_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (req_vld_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1: got req_vld_o=%0b, expected 0 in reset", req_vld_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    port_rdy_i = '1;
    expect_none(10, "R1 idle before start");

    // Table-driven pass
    cfg_write(5'd0, 32'd0,   32'd64,   7'd16);
    cfg_write(5'd1, 32'd100, 32'd108,  7'd8);
    cfg_write(5'd2, 32'd200, 32'd1000, 7'd4);
    cfg_write(5'd3, 32'd300, 32'd1000, 7'd32);
    cfg_write(5'd5, 32'd500, 32'd1000, 7'd1);
    do_start(6'd4, 32'h0000_002F);
    foreach (TBL[i]) begin
      if (TBL[i].dn) pulse_done(TBL[i].di);
      if (TBL[i].ev) pop_expect(TBL[i].ei, TBL[i].eb, TBL[i].ea, $sformatf("R4 row %0d", i));
      else           expect_none(14, $sformatf("R8/R2 row %0d", i));
    end

    // R3: not-ready port skipped, disabled port never granted; R10 restart re-arms flags
    port_rdy_i = 32'hFFFF_FFFD;
    cfg_write(5'd0, 32'd10, 32'd900, 7'd1);
    cfg_write(5'd1, 32'd20, 32'd900, 7'd1);
    cfg_write(5'd2, 32'd30, 32'd900, 7'd1);
    cfg_write(5'd3, 32'd40, 32'd900, 7'd1);
    do_start(6'd4, 32'h0000_000B);
    pop_expect(5'd0, 7'd1, 32'd10, "R10 restart at port 0");
    pop_expect(5'd3, 7'd1, 32'd40, "R3 skip not-ready and disabled");
    expect_none(10, "R3 not-ready port held");
    port_rdy_i = '1;
    pop_expect(5'd1, 7'd1, 32'd20, "R3 granted once ready");
    expect_none(10, "R3 disabled port never granted");

    // R6: clear port 0 and set port 1 in the same cycle
    port_rdy_i = 32'h0000_0002;
    cfg_write(5'd0, 32'd1000, 32'd5000, 7'd1);
    cfg_write(5'd1, 32'd2000, 32'd5000, 7'd1);
    start_i = 1'b1; num_ports_i = 6'd2; en_mask_i = 32'h3;
    @(negedge clk_i);           // pointer 0
    start_i = 1'b0;
    @(negedge clk_i);           // pointer 1, port 1 granted
    @(negedge clk_i);           // pointer 0
    port_rdy_i = 32'h0000_0003; done_i = 1'b1; done_idx_i = 5'd1;
    @(negedge clk_i);
    done_i = 1'b0;
    pop_expect(5'd1, 7'd1, 32'd2000, "R6 first grant port 1");
    pop_expect(5'd0, 7'd1, 32'd1000, "R6 grant port 0 with set of 1");
    pop_expect(5'd1, 7'd1, 32'd2001, "R6 set of port 1 kept");
    expect_none(12, "R6 clear of port 0 kept");

    // R7: grant and completion of the same port in one cycle
    port_rdy_i = '0;
    cfg_write(5'd0, 32'd3000, 32'd9000, 7'd1);
    do_start(6'd1, 32'h1);
    @(negedge clk_i);
    port_rdy_i = 32'h1; done_i = 1'b1; done_idx_i = 5'd0;
    @(negedge clk_i);
    done_i = 1'b0;
    pop_expect(5'd0, 7'd1, 32'd3000, "R7 single entry");
    expect_none(12, "R7 clear wins");

    // R9: queue full holds polling, completion during hold not lost
    port_rdy_i = '1;
    for (int p = 0; p < 4; p++) cfg_write(5'(p), 32'(4000 + 100 * p), 32'd9000, 7'd2);
    do_start(6'd4, 32'hF);
    repeat (12) @(negedge clk_i);
    n_chk++;
    if (req_vld_o !== 1'b1) begin
      n_err++;
      $display("FAIL R9: got req_vld_o=%0b, expected 1 with full queue", req_vld_o);
    end
    pulse_done(5'd0);
    repeat (8) @(negedge clk_i);
    pop_expect(5'd0, 7'd2, 32'd4000, "R9 order 0");
    pop_expect(5'd1, 7'd2, 32'd4100, "R9 order 1");
    pop_expect(5'd2, 7'd2, 32'd4200, "R9 order 2");
    pop_expect(5'd3, 7'd2, 32'd4300, "R9 order 3");
    pop_expect(5'd0, 7'd2, 32'd4002, "R9 resume after pop");
    expect_none(12, "R9 no extra entries");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule